// File: doc/BRIEF.md
# SMBus Block Transfer Buffer Engine

This block is the block-transfer data path of an SMBus host controller. Software sets a byte count and a payload through a small register port and starts a block write or a block read. The block then drives a byte-level bus engine one byte at a time: a count byte, the payload bytes, and finally a stop. The address phase, PEC generation and bus timing belong to neighbouring logic.

There are two data modes, selected by an auxiliary control bit that is sampled at start. In buffer mode the whole payload sits in a 32-entry store behind a single block-data port. Each access to that port advances an internal index, and a read of the control register sets the index back to zero. In byte-by-byte mode the block stops after every payload byte, raises a byte-done flag and issues no further bus command until software clears the flag. Software moves each byte through a one-byte holding register. It ends a read early by switching the control command to the last-byte variant.

Top module: `smbus_blkbuf_top`

## Requirements
- R1: After reset the status, control, count and auxiliary registers read 0 and no bus command is requested.
- R2: Auxiliary register (offset 4) bit 1 selects buffer mode and reads back as 1 only when the buffer is built in. Bit 0 stores the PEC enable and reads back as written.
- R3: In buffer mode each read or write of the block-data port (offset 3) moves the buffer index up by one. A read of the control register (offset 1) sets the index to 0.
- R4: A buffer-mode write, started by writing 0x54 to control, first sends the count from the count register (offset 2) and then the buffered bytes in index order, then a stop. Bus opcodes: 0 write byte, 1 read with ACK, 2 read with NACK, 3 stop. An issued command stays requested and unchanged until the bus engine reports done.
- R5: A buffer-mode read, started with 0x55, reads the count byte with ACK and stores it in the count register. It then reads that many bytes into the buffer, ACKing all but the last, which gets a NACK, then sends a stop.
- R6: In byte-by-byte mode, after each payload byte status bit 7 (0x80) is set and no bus command is requested until software writes 1 to that bit.
- R7: In a byte-by-byte read, a byte is read with NACK, and the stop follows it, when the control command in force is the last-byte command 0x34 (bit 5 set) or the byte is the last one by count.
- R8: In a byte-by-byte read, the received count is in the count register when byte-done first rises, and each data byte is in the holding register when its byte-done rises.
- R9: In a byte-by-byte write, the first payload byte is taken from the holding register written before start. Each later byte is taken from that register when byte-done is cleared.
- R10: A received count of 0 or above 32, or a write count of 0, sets the failed flag (0x10), sends a stop, never sets done, and leaves the buffer and count register unchanged.
- R11: Busy (0x01) is set from the cycle after start until the stop completes. Done (0x02) is set only after the stop, with busy already clear. Done, failed and byte-done are cleared by writing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies read side effects) |
| reg_addr | input | 3 | Register offset: 0 status, 1 control, 2 count, 3 block data, 4 auxiliary |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| cmd_valid | output | 1 | Bus byte command requested |
| cmd_op | output | 2 | Bus opcode: 0 write, 1 read ACK, 2 read NACK, 3 stop |
| cmd_wdata | output | 8 | Byte to send for a write command |
| cmd_done | input | 1 | Bus engine finished the requested command |
| cmd_rdata | input | 8 | Byte received by a read command |

## Verification
The bench aims at the early end of a byte-by-byte read. It switches to the last-byte command after the first of five counted bytes. A design that ignored the command would keep ACKing and read past the point where the stop belongs. It checks that a bad received count of 0 or 40 ends in a stop with failed set and the old buffer contents intact. A design that trusted the count would overwrite the payload or report done. It also holds the byte-done stall for several idle cycles and confirms that no command leaks out. Finally it checks that the received count is visible before the first byte-done, where a late update would hand software a stale length.

// File: rtl/smb_blk_pkg.sv
// Shared encodings of the SMBus block transfer engine.
// Assumes register offsets and status bit positions are fixed by software.
package smb_blk_pkg;

    typedef enum logic [1:0] {
        OP_WR      = 2'd0,
        OP_RD_ACK  = 2'd1,
        OP_RD_NACK = 2'd2,
        OP_STOP    = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CNT,
        S_DATA,
        S_WAIT,
        S_STOP
    } seq_st_e;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_CNT  = 3'd2;
    localparam logic [2:0] A_BLK  = 3'd3;
    localparam logic [2:0] A_AUX  = 3'd4;

    localparam int ST_BDONE = 7;
    localparam int ST_FAIL  = 4;
    localparam int ST_DONE  = 1;
    localparam int ST_BUSY  = 0;

    localparam int CTL_START = 6;
    localparam int CTL_LAST  = 5;
    localparam int CTL_DIR   = 0;
    localparam logic [2:0] CTL_BLOCK_CODE = 3'b101;

endpackage

// File: rtl/smb_blk_buf.sv
// Payload store with a software port and an engine port.
// Assumes the engine port wins when both write in the same cycle.
module smb_blk_buf #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [7:0]       sw_wdata,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [7:0]       eng_wdata,
    output logic [7:0]       sw_rdata,
    output logic [7:0]       eng_rdata
);

    logic [7:0] mem [DEPTH];

    // Write one entry per cycle, engine first.
    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem[eng_idx] <= eng_wdata;
        end else if (sw_we) begin
            mem[sw_idx] <= sw_wdata;
        end
    end

    // Asynchronous read on both ports.
    always_comb begin
        sw_rdata  = mem[sw_idx];
        eng_rdata = mem[eng_idx];
    end

endmodule

// File: rtl/smb_blk_seq.sv
// Transfer sequencer: count byte, payload bytes, stop. It also owns the
// status flags. Assumes cmd_done pulses for one cycle per command.
module smb_blk_seq
    import smb_blk_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int IDX_W   = $clog2(MAX_LEN),
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rd,
    input  logic             buf_mode,
    input  logic [7:0]       cnt_in,
    input  logic [7:0]       hold_in,
    input  logic             ctrl_last,
    input  logic [7:0]       buf_rd,
    input  logic [7:0]       stat_clr,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_wdata,
    input  logic             cmd_done,
    input  logic [7:0]       cmd_rdata,
    output logic             busy,
    output logic             bdone,
    output logic             xfail,
    output logic             xdone,
    output logic             buf_we,
    output logic [IDX_W-1:0] eng_idx,
    output logic             cnt_we,
    output logic             hold_we
);

    localparam logic [7:0] MAX_B = 8'(MAX_LEN);

    seq_st_e          st;
    logic             rd_q, bm_q, last_q, fin_q, err_q;
    logic [CNT_W-1:0] len_q, nxt_q;
    logic             is_last, data_fin, cnt_bad, wcnt_bad;

    // Decide whether the current read byte is the final one.
    always_comb begin
        is_last  = (nxt_q == (len_q - 1'b1)) || (!bm_q && last_q);
        data_fin = rd_q ? is_last : ((nxt_q + 1'b1) == len_q);
        cnt_bad  = (cmd_rdata == 8'd0) || (cmd_rdata > MAX_B);
        wcnt_bad = (cnt_in == 8'd0) || (cnt_in > MAX_B);
    end

    // Present the bus command for the current state.
    always_comb begin
        cmd_valid = (st == S_CNT) || (st == S_DATA) || (st == S_STOP);
        cmd_op    = OP_WR;
        cmd_wdata = 8'd0;
        case (st)
            S_CNT: begin
                cmd_op    = rd_q ? OP_RD_ACK : OP_WR;
                cmd_wdata = 8'(len_q);
            end
            S_DATA: begin
                if (rd_q) cmd_op = is_last ? OP_RD_NACK : OP_RD_ACK;
                else      cmd_op = OP_WR;
                cmd_wdata = bm_q ? buf_rd : hold_in;
            end
            S_STOP:  cmd_op = OP_STOP;
            default: cmd_op = OP_WR;
        endcase
    end

    // Engine-side write strobes into the count, holding and buffer stores.
    always_comb begin
        eng_idx = nxt_q[IDX_W-1:0];
        cnt_we  = (st == S_CNT) && cmd_done && rd_q && !cnt_bad;
        buf_we  = (st == S_DATA) && cmd_done && rd_q && bm_q;
        hold_we = (st == S_DATA) && cmd_done && rd_q && !bm_q;
    end

    // Sequence the transfer and update status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            rd_q   <= 1'b0;
            bm_q   <= 1'b0;
            last_q <= 1'b0;
            fin_q  <= 1'b0;
            err_q  <= 1'b0;
            len_q  <= '0;
            nxt_q  <= '0;
            busy   <= 1'b0;
            bdone  <= 1'b0;
            xfail  <= 1'b0;
            xdone  <= 1'b0;
        end else begin
            if (stat_clr[ST_BDONE]) bdone <= 1'b0;
            if (stat_clr[ST_FAIL])  xfail <= 1'b0;
            if (stat_clr[ST_DONE])  xdone <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    busy  <= 1'b1;
                    rd_q  <= start_rd;
                    bm_q  <= buf_mode;
                    nxt_q <= '0;
                    len_q <= cnt_in[CNT_W-1:0];
                    if (!start_rd && wcnt_bad) begin
                        xfail <= 1'b1;
                        err_q <= 1'b1;
                        st    <= S_STOP;
                    end else begin
                        st <= S_CNT;
                    end
                end
                S_CNT: if (cmd_done) begin
                    if (rd_q && cnt_bad) begin
                        xfail <= 1'b1;
                        err_q <= 1'b1;
                        st    <= S_STOP;
                    end else begin
                        if (rd_q) len_q <= cmd_rdata[CNT_W-1:0];
                        last_q <= ctrl_last;
                        st     <= S_DATA;
                    end
                end
                S_DATA: if (cmd_done) begin
                    nxt_q <= nxt_q + 1'b1;
                    if (!bm_q) begin
                        bdone <= 1'b1;
                        fin_q <= data_fin;
                        st    <= S_WAIT;
                    end else begin
                        st <= data_fin ? S_STOP : S_DATA;
                    end
                end
                S_WAIT: if (!bdone) begin
                    last_q <= ctrl_last;
                    st     <= fin_q ? S_STOP : S_DATA;
                end
                S_STOP: if (cmd_done) begin
                    busy  <= 1'b0;
                    if (!err_q) xdone <= 1'b1;
                    err_q <= 1'b0;
                    st    <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/smbus_blkbuf_top.sv
// SMBus block transfer engine: register decode, index, count and holding
// registers, payload buffer and sequencer. Assumes one register access per
// cycle; reg_rdata is combinational and reg_rd only applies side effects.
module smbus_blkbuf_top
    import smb_blk_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int BUF_EN  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic [7:0] cmd_wdata,
    input  logic       cmd_done,
    input  logic [7:0] cmd_rdata
);

    localparam int IDX_W = $clog2(MAX_LEN);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    logic [7:0]       ctrl_q, data0_q, hold_q;
    logic [1:0]       aux_q, aux_mask;
    logic [IDX_W-1:0] sw_idx, eng_idx;
    logic [7:0]       sw_rdata, eng_rdata, stat_clr;
    logic             busy, bdone, xfail, xdone;
    logic             buf_we, cnt_we, hold_we, start;
    logic             wr_ctrl, wr_blk, rd_ctrl, rd_blk;

    // Buffer-mode bit is writable only when the buffer is built in.
    generate
        if (BUF_EN != 0) begin : g_buf_on
            assign aux_mask = 2'b11;
        end else begin : g_buf_off
            assign aux_mask = 2'b01;
        end
    endgenerate

    // Decode register strobes and the start command.
    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
        wr_blk   = reg_wr && (reg_addr == A_BLK);
        rd_ctrl  = reg_rd && (reg_addr == A_CTRL);
        rd_blk   = reg_rd && (reg_addr == A_BLK);
        start    = wr_ctrl && reg_wdata[CTL_START] && !busy &&
                   (reg_wdata[4:2] == CTL_BLOCK_CODE);
        stat_clr = (reg_wr && (reg_addr == A_STAT)) ? reg_wdata : 8'd0;
    end

    // Software-visible registers and the buffer index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= 8'd0;
            data0_q <= 8'd0;
            hold_q  <= 8'd0;
            aux_q   <= 2'd0;
            sw_idx  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata & 8'hBF;
            if (cnt_we) data0_q <= cmd_rdata;
            else if (reg_wr && (reg_addr == A_CNT) && !busy) data0_q <= reg_wdata;
            if (hold_we) hold_q <= cmd_rdata;
            else if (wr_blk && !aux_q[1]) hold_q <= reg_wdata;
            if (reg_wr && (reg_addr == A_AUX)) aux_q <= reg_wdata[1:0] & aux_mask;
            if (rd_ctrl) sw_idx <= '0;
            else if ((wr_blk || rd_blk) && aux_q[1]) sw_idx <= sw_idx + 1'b1;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = {bdone, 2'b00, xfail, 2'b00, xdone, busy};
            A_CTRL:  reg_rdata = ctrl_q;
            A_CNT:   reg_rdata = data0_q;
            A_BLK:   reg_rdata = aux_q[1] ? sw_rdata : hold_q;
            A_AUX:   reg_rdata = {6'd0, aux_q};
            default: reg_rdata = 8'd0;
        endcase
    end

    smb_blk_buf #(.DEPTH(MAX_LEN), .IDX_W(IDX_W)) u_buf (
        .clk       (clk),
        .sw_we     (wr_blk && aux_q[1]),
        .sw_idx    (sw_idx),
        .sw_wdata  (reg_wdata),
        .eng_we    (buf_we),
        .eng_idx   (eng_idx),
        .eng_wdata (cmd_rdata),
        .sw_rdata  (sw_rdata),
        .eng_rdata (eng_rdata)
    );

    smb_blk_seq #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_rd  (reg_wdata[CTL_DIR]),
        .buf_mode  (aux_q[1]),
        .cnt_in    (data0_q),
        .hold_in   (hold_q),
        .ctrl_last (ctrl_q[CTL_LAST]),
        .buf_rd    (eng_rdata),
        .stat_clr  (stat_clr),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .cmd_done  (cmd_done),
        .cmd_rdata (cmd_rdata),
        .busy      (busy),
        .bdone     (bdone),
        .xfail     (xfail),
        .xdone     (xdone),
        .buf_we    (buf_we),
        .eng_idx   (eng_idx),
        .cnt_we    (cnt_we),
        .hold_we   (hold_we)
    );

endmodule

// File: rtl/smb_blk_chk.sv
// Protocol checker for the SMBus block transfer engine, bound to the top.
// Assumes cmd_done is only asserted while a command is requested.
module smb_blk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       cmd_done,
    input logic       busy,
    input logic       bdone,
    input logic       xdone,
    input logic       xfail
);

    // R11: bus activity only inside a busy transfer.
    p_cmd_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // R6: byte-done stalls the bus.
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bdone |-> !cmd_valid);

    // R4: a requested command is held unchanged until done.
    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op)));

    // R11: done rises only right after a completed stop.
    p_done_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xdone) |-> $past(cmd_valid && cmd_done && (cmd_op == 2'd3)));

    // R11: busy is already clear when done appears.
    p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xdone) |-> !busy);

    // R10: a failed transfer never reports done.
    p_fail_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfail |-> !$rose(xdone));

endmodule

bind smbus_blkbuf_top smb_blk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_done  (cmd_done),
    .busy      (busy),
    .bdone     (bdone),
    .xdone     (xdone),
    .xfail     (xfail)
);

// File: tb/sim_smbus_blkbuf_top.sv
`timescale 1ns/1ps
// Directed bench for the SMBus block transfer engine with a bus engine model.
module sim_smbus_blkbuf_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [7:0] cmd_wdata;
    logic       cmd_done = 1'b0;
    logic [7:0] cmd_rdata = 8'd0;

    int checks = 0;
    int errors = 0;

    logic [1:0] op_log [0:63];
    logic [7:0] dat_log [0:63];
    int         log_n = 0;
    logic [7:0] rx_q [0:15];
    int         rx_p = 0;
    int         lat = 0;

    always #10 clk = ~clk;

    smbus_blkbuf_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
    );

    // Bus engine model: completes each command two cycles after request.
    always @(negedge clk) begin
        if (cmd_done) begin
            cmd_done = 1'b0;
        end else if (cmd_valid && rst_n) begin
            if (lat == 1) begin
                op_log[log_n]  = cmd_op;
                dat_log[log_n] = cmd_wdata;
                log_n++;
                cmd_rdata = (cmd_op == 2'd1 || cmd_op == 2'd2) ? rx_q[rx_p] : 8'd0;
                if (cmd_op == 2'd1 || cmd_op == 2'd2) rx_p++;
                cmd_done = 1'b1;
                lat = 0;
            end else begin
                lat++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_stat(input logic [7:0] mask);
        logic [7:0] v;
        v = 8'd0;
        while ((v & mask) == 8'd0) rd(3'd0, v);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        v = 8'h01;
        while (v[0]) rd(3'd0, v);
    endtask

    task automatic chk_op(input string req, input int i, input int op, input int d);
        chk(req, op_log[i], op);
        if (op == 0) chk(req, dat_log[i], d);
    endtask

    // R1: reset values.
    task automatic t_reset();
        logic [7:0] v;
        rd(3'd0, v); chk("R1 status", v, 8'h00);
        rd(3'd1, v); chk("R1 control", v, 8'h00);
        rd(3'd2, v); chk("R1 count", v, 8'h00);
        rd(3'd4, v); chk("R1 aux", v, 8'h00);
        chk("R1 cmd_valid", cmd_valid, 0);
    endtask

    // R2: auxiliary bits read back.
    task automatic t_aux();
        logic [7:0] v;
        wr(3'd4, 8'h03); rd(3'd4, v); chk("R2 aux both", v, 8'h03);
        wr(3'd4, 8'h02); rd(3'd4, v); chk("R2 aux buffer", v, 8'h02);
    endtask

    // R3: auto-increment and index reset by control read.
    task automatic t_index();
        logic [7:0] v;
        rd(3'd1, v);
        wr(3'd3, 8'hA1); wr(3'd3, 8'hA2); wr(3'd3, 8'hA3);
        rd(3'd1, v);
        rd(3'd3, v); chk("R3 idx0", v, 8'hA1);
        rd(3'd3, v); chk("R3 idx1", v, 8'hA2);
        rd(3'd1, v);
        rd(3'd3, v); chk("R3 idx reset", v, 8'hA1);
    endtask

    // R4, R11: buffer-mode write.
    task automatic t_buf_write();
        logic [7:0] v;
        wr(3'd2, 8'd4);
        rd(3'd1, v);
        wr(3'd3, 8'h11); wr(3'd3, 8'h22); wr(3'd3, 8'h33); wr(3'd3, 8'h44);
        log_n = 0;
        wr(3'd1, 8'h54);
        rd(3'd0, v); chk("R11 busy after start", v & 8'h03, 8'h01);
        wait_idle();
        rd(3'd0, v); chk("R11 done after stop", v, 8'h02);
        chk("R4 op count", log_n, 6);
        chk_op("R4 count byte", 0, 0, 4);
        chk_op("R4 byte0", 1, 0, 8'h11);
        chk_op("R4 byte1", 2, 0, 8'h22);
        chk_op("R4 byte2", 3, 0, 8'h33);
        chk_op("R4 byte3", 4, 0, 8'h44);
        chk_op("R4 stop", 5, 3, 0);
        wr(3'd0, 8'h02); rd(3'd0, v); chk("R11 done w1c", v, 8'h00);
    endtask

    // R5: buffer-mode read.
    task automatic t_buf_read();
        logic [7:0] v;
        rx_q[0] = 8'd3; rx_q[1] = 8'hB0; rx_q[2] = 8'hB1; rx_q[3] = 8'hB2;
        rx_p = 0; log_n = 0;
        wr(3'd1, 8'h55);
        wait_idle();
        rd(3'd0, v); chk("R5 done", v, 8'h02);
        rd(3'd2, v); chk("R5 count stored", v, 8'd3);
        rd(3'd1, v);
        rd(3'd3, v); chk("R5 data0", v, 8'hB0);
        rd(3'd3, v); chk("R5 data1", v, 8'hB1);
        rd(3'd3, v); chk("R5 data2", v, 8'hB2);
        chk("R5 op count", log_n, 5);
        chk_op("R5 count ack", 0, 1, 0);
        chk_op("R5 ack1", 2, 1, 0);
        chk_op("R5 nack last", 3, 2, 0);
        chk_op("R5 stop", 4, 3, 0);
        wr(3'd0, 8'h02);
    endtask

    // R10: bad received and written counts.
    task automatic t_bad_count(input logic [7:0] bad);
        logic [7:0] v;
        rx_q[0] = bad; rx_q[1] = 8'hEE; rx_p = 0; log_n = 0;
        wr(3'd1, 8'h55);
        wait_idle();
        rd(3'd0, v); chk("R10 failed no done", v, 8'h10);
        chk("R10 op count", log_n, 2);
        chk_op("R10 stop", 1, 3, 0);
        rd(3'd2, v); chk("R10 count kept", v, 8'd3);
        rd(3'd1, v);
        rd(3'd3, v); chk("R10 buffer kept", v, 8'hB0);
        wr(3'd0, 8'h10); rd(3'd0, v); chk("R11 failed w1c", v, 8'h00);
    endtask

    task automatic t_bad_wcount();
        logic [7:0] v;
        wr(3'd2, 8'd0); log_n = 0;
        wr(3'd1, 8'h54);
        wait_idle();
        rd(3'd0, v); chk("R10 write count 0", v, 8'h10);
        chk("R10 only stop", log_n, 1);
        chk_op("R10 stop op", 0, 3, 0);
        wr(3'd0, 8'h10);
    endtask

    // R6, R9: byte-by-byte write.
    task automatic t_byte_write();
        logic [7:0] v;
        wr(3'd4, 8'h00);
        wr(3'd2, 8'd3); wr(3'd3, 8'hC0);
        log_n = 0;
        wr(3'd1, 8'h54);
        wait_stat(8'h80);
        repeat (5) @(negedge clk);
        chk("R6 stalled no cmd", cmd_valid, 0);
        chk("R6 stalled log", log_n, 2);
        wr(3'd3, 8'hC1); wr(3'd0, 8'h80);
        wait_stat(8'h80);
        wr(3'd3, 8'hC2); wr(3'd0, 8'h80);
        wait_stat(8'h80);
        wr(3'd0, 8'h80);
        wait_idle();
        rd(3'd0, v); chk("R11 byte write done", v, 8'h02);
        chk("R9 op count", log_n, 5);
        chk_op("R9 count", 0, 0, 3);
        chk_op("R9 first byte", 1, 0, 8'hC0);
        chk_op("R9 second byte", 2, 0, 8'hC1);
        chk_op("R9 third byte", 3, 0, 8'hC2);
        chk_op("R9 stop", 4, 3, 0);
        wr(3'd0, 8'h02);
    endtask

    // R7, R8: byte-by-byte read ending by count with last command.
    task automatic t_byte_read();
        logic [7:0] v;
        rx_q[0] = 8'd3; rx_q[1] = 8'hD0; rx_q[2] = 8'hD1; rx_q[3] = 8'hD2;
        rx_p = 0; log_n = 0;
        wr(3'd1, 8'h55);
        wait_stat(8'h80);
        rd(3'd2, v); chk("R8 count before first byte", v, 8'd3);
        rd(3'd3, v); chk("R8 first byte", v, 8'hD0);
        wr(3'd0, 8'h80);
        wait_stat(8'h80);
        rd(3'd3, v); chk("R8 second byte", v, 8'hD1);
        wr(3'd1, 8'h35); wr(3'd0, 8'h80);
        wait_stat(8'h80);
        rd(3'd3, v); chk("R8 third byte", v, 8'hD2);
        wr(3'd0, 8'h80);
        wait_idle();
        chk("R7 op count", log_n, 5);
        chk_op("R7 ack before last", 2, 1, 0);
        chk_op("R7 nack last", 3, 2, 0);
        chk_op("R7 stop", 4, 3, 0);
        wr(3'd0, 8'h02);
    endtask

    // R7: last-byte command ends the read before the count runs out.
    task automatic t_early_last();
        logic [7:0] v;
        rx_q[0] = 8'd5; rx_q[1] = 8'hE0; rx_q[2] = 8'hE1; rx_q[3] = 8'hE2;
        rx_p = 0; log_n = 0;
        wr(3'd1, 8'h55);
        wait_stat(8'h80);
        wr(3'd1, 8'h35); wr(3'd0, 8'h80);
        wait_stat(8'h80);
        rd(3'd3, v); chk("R7 early byte", v, 8'hE1);
        wr(3'd0, 8'h80);
        wait_idle();
        rd(3'd0, v); chk("R7 early done", v, 8'h02);
        chk("R7 early op count", log_n, 4);
        chk_op("R7 early nack", 2, 2, 0);
        chk_op("R7 early stop", 3, 3, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_aux();
        t_index();
        t_buf_write();
        t_buf_read();
        t_bad_count(8'd0);
        t_bad_count(8'd40);
        t_bad_wcount();
        t_byte_write();
        t_byte_read();
        t_early_last();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule